// File: doc/BRIEF.md
# Sample-Rate Timing Select Divider

This block produces one timing pulse stream for each of two sample-rate-converter channels. Both channels are configured through a single 32-bit select register, split into one 16-bit lane per channel. Each lane names a source and a divider index. The source can be one of three reference tick inputs, one of two baud-generator tick inputs, or the word-select strobe of a serial port. All of these inputs are single-cycle enable pulses on the one system clock.

A reference or baud source is counted down by a factor taken from a fixed, roughly geometric table. The table grows in alternating steps of ×4/3 and ×1.5, so every second entry doubles. A strobe source is passed through without division. Each countable source is gated by its own bit of a divider-enable input. Each channel runs a three-state machine:

- `M_HOLD`: counter held at zero, no output.
- `M_RUN`: counting source ticks.
- `M_PASS`: strobe pass-through.

The next state is decoded every cycle from the channel's field, or from the field being written, together with the enable bits. The transitions are:

- Any state goes to `M_HOLD` when the source is disabled, the index is reserved, or the source is unconnected.
- Any state goes to `M_RUN` when a countable source is enabled with a valid index.
- Any state goes to `M_PASS` when the select names a connected strobe.

Top module: `tsd_timing_sel`

## Requirements
- R1: While reset is active and after its release, both pulse outputs are low, both lanes hold zero and both state machines are in `M_HOLD`.
- R2: `wr_lane[c]` high loads lane c from `wr_data[16c+15:16c]`, keeping only the select in bits 11:8 and the index in bits 4:0. All other bits of the lane are ignored.
- R3: Select codes 0, 1 and 2 count `ref_tick[0]`, `ref_tick[1]` and `ref_tick[2]`. Codes 3 and 4 count `brg_tick[0]` and `brg_tick[1]`.
- R4: Indices 0 to 3 divide by 2, 4, 6 and 8.
- R5: Indices 4 to 28 divide by 12, 16, 24, 32, and so on, with each entry twice the entry two places before it. Index 28 divides by 49152.
- R6: Index 29 divides by 98304, and no index divides by 65536.
- R7: A countable source with code s runs only while `div_en[s+1]` is high. While disabled, its counter stays at zero. An enable change first governs the ticks of the clock cycle after the one in which it changes.
- R8: Select codes 6 and above pass `ws_tick[code-6]` through one-for-one, one cycle late. Code 5, and codes whose strobe number is at least NUM_WS, give no pulses.
- R9: Indices 30 and 31 give no pulses.
- R10: Writing a lane clears that channel's counter and output. A tick arriving in the write cycle is not counted, and the first pulse follows the factor-th tick after the write.
- R11: A divided channel raises `tick_out` for exactly one cycle, in the cycle after the tick that completes its count. With no tick on any source, no pulse follows.
- R12: Writing one lane leaves the other lane's field and counter untouched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lane | input | NUM_CH | Per-lane write strobe of the select register |
| wr_data | input | 16*NUM_CH | Select register write data |
| div_en | input | 5 (bits 5:1) | Divider enable, bit s+1 for source code s |
| ref_tick | input | 3 | Reference input tick pulses |
| brg_tick | input | 2 | Baud-generator tick pulses |
| ws_tick | input | NUM_WS | Serial-port word-select strobes |
| tick_out | output | NUM_CH | Timing pulse per channel |

## Verification
The bench builds the block with NUM_WS = 8. This leaves select codes 14 and 15 naming strobes that do not exist, so the unconnected pass-through case (R8) can be reached alongside the connected strobes 0 to 7. NUM_CH keeps its default of 2, so the lane independence and the write-clears-counter behaviour are exercised on both halves of the 32-bit register. A long run at one tick per cycle reaches index 28 twice and index 29 once, which shows that 65536 is skipped.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

    localparam int LANE_W   = 16;
    localparam int FACTOR_W = 17;

    typedef enum logic [1:0] {
        M_HOLD = 2'd0,
        M_RUN  = 2'd1,
        M_PASS = 2'd2
    } tsd_mode_t;

    typedef struct packed {
        logic [3:0] sel;
        logic [4:0] idx;
    } tsd_field_t;

    // Division factor for an index; zero marks a reserved index.
    function automatic logic [FACTOR_W-1:0] tsd_factor(input logic [4:0] idx);
        logic [4:0] k;
        logic [FACTOR_W-1:0] base;
        if (idx < 5'd4) begin
            return FACTOR_W'((idx + 5'd1) * 2);
        end else if (idx <= 5'd28) begin
            k    = idx - 5'd4;
            base = k[0] ? FACTOR_W'(16) : FACTOR_W'(12);
            return base << k[4:1];
        end else if (idx == 5'd29) begin
            return FACTOR_W'(98304);
        end
        return '0;
    endfunction

    function automatic tsd_mode_t tsd_mode(input logic [3:0] sel,
                                           input logic [4:0] idx,
                                           input logic [5:1] en,
                                           input int         num_ws);
        if (sel <= 4'd4) begin
            return (en[int'(sel) + 1] && idx < 5'd30) ? M_RUN : M_HOLD;
        end else if (sel == 4'd5) begin
            return M_HOLD;
        end else if (int'(sel) - 6 < num_ws) begin
            return M_PASS;
        end
        return M_HOLD;
    endfunction

endpackage

// File: rtl/tsd_src_mux.sv
module tsd_src_mux #(
    parameter int NUM_WS = 10
) (
    input  logic [3:0]        sel,
    input  logic [2:0]        ref_tick,
    input  logic [1:0]        brg_tick,
    input  logic [NUM_WS-1:0] ws_tick,
    output logic              tick
);

    always_comb begin
        tick = 1'b0;
        if (sel <= 4'd2) begin
            tick = ref_tick[sel[1:0]];
        end else if (sel <= 4'd4) begin
            tick = brg_tick[sel == 4'd4];
        end else begin
            for (int k = 0; k < NUM_WS; k++) begin
                if (sel == 4'(k + 6)) tick = ws_tick[k];
            end
        end
    end

endmodule

// File: rtl/tsd_chan.sv
module tsd_chan
    import tsd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clr,
    input  tsd_mode_t           nxt_mode,
    input  logic                src_tick,
    input  logic [FACTOR_W-1:0] factor,
    output logic                pulse
);

    tsd_mode_t           st;
    logic [FACTOR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= M_HOLD;
        else        st <= nxt_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else if (clr) begin
            cnt   <= '0;
            pulse <= 1'b0;
        end else begin
            unique case (st)
                M_HOLD: begin
                    cnt   <= '0;
                    pulse <= 1'b0;
                end
                M_RUN: begin
                    pulse <= 1'b0;
                    if (src_tick) begin
                        if (cnt == factor - FACTOR_W'(1)) begin
                            cnt   <= '0;
                            pulse <= 1'b1;
                        end else begin
                            cnt <= cnt + FACTOR_W'(1);
                        end
                    end
                end
                M_PASS: begin
                    cnt   <= '0;
                    pulse <= src_tick;
                end
                default: begin
                    cnt   <= '0;
                    pulse <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/tsd_timing_sel.sv
module tsd_timing_sel
    import tsd_pkg::*;
#(
    parameter int NUM_WS = 10,
    parameter int NUM_CH = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CH-1:0]          wr_lane,
    input  logic [LANE_W*NUM_CH-1:0]   wr_data,
    input  logic [5:1]                 div_en,
    input  logic [2:0]                 ref_tick,
    input  logic [1:0]                 brg_tick,
    input  logic [NUM_WS-1:0]          ws_tick,
    output logic [NUM_CH-1:0]          tick_out
);

    tsd_field_t [NUM_CH-1:0] cfg_q;
    tsd_field_t [NUM_CH-1:0] field_wr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (wr_lane[c]) cfg_q[c] <= field_wr[c];
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        tsd_field_t          cfg_d;
        tsd_mode_t           nxt_mode;
        logic                src_tick;
        logic [FACTOR_W-1:0] factor;
        logic                lane_unused;

        assign field_wr[c].sel = wr_data[c*LANE_W + 8 +: 4];
        assign field_wr[c].idx = wr_data[c*LANE_W +: 5];
        assign lane_unused     = ^{wr_data[c*LANE_W + 12 +: 4],
                                   wr_data[c*LANE_W + 5 +: 3]};

        assign cfg_d    = wr_lane[c] ? field_wr[c] : cfg_q[c];
        assign nxt_mode = tsd_mode(cfg_d.sel, cfg_d.idx, div_en, NUM_WS);
        assign factor   = tsd_factor(cfg_q[c].idx);

        tsd_src_mux #(.NUM_WS(NUM_WS)) u_mux (
            .sel      (cfg_q[c].sel),
            .ref_tick (ref_tick),
            .brg_tick (brg_tick),
            .ws_tick  (ws_tick),
            .tick     (src_tick)
        );

        tsd_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (wr_lane[c]),
            .nxt_mode (nxt_mode),
            .src_tick (src_tick),
            .factor   (factor),
            .pulse    (tick_out[c])
        );
    end

endmodule

// File: rtl/tsd_timing_sel_chk.sv
module tsd_timing_sel_chk
    import tsd_pkg::*;
#(
    parameter int NUM_WS = 10,
    parameter int NUM_CH = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_CH-1:0]        wr_lane,
    input logic [2:0]               ref_tick,
    input logic [1:0]               brg_tick,
    input logic [NUM_WS-1:0]        ws_tick,
    input tsd_field_t [NUM_CH-1:0]  cfg_q,
    input logic [NUM_CH-1:0]        tick_out
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R8: strobe 0 selected, no write -> output mirrors strobe one cycle late
        p_strobe_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[c].sel == 4'd6 && !wr_lane[c]) |=> (tick_out[c] == $past(ws_tick[0])));

        // R9: reserved index on a countable source stays silent
        p_reserved_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[c].sel <= 4'd4 && cfg_q[c].idx >= 5'd30) |=> !tick_out[c]);

        // R10: a lane write clears the output
        p_write_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
            wr_lane[c] |=> !tick_out[c]);

        // R11: no source tick anywhere -> no pulse next cycle
        p_no_tick_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
            (ref_tick == '0 && brg_tick == '0 && ws_tick == '0) |=> !tick_out[c]);

        // R12: a lane not written keeps its field
        p_lane_keep_r12: assert property (@(posedge clk) disable iff (!rst_n)
            !wr_lane[c] |=> (cfg_q[c] == $past(cfg_q[c])));
    end

endmodule

bind tsd_timing_sel tsd_timing_sel_chk #(.NUM_WS(NUM_WS), .NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lane  (wr_lane),
    .ref_tick (ref_tick),
    .brg_tick (brg_tick),
    .ws_tick  (ws_tick),
    .cfg_q    (cfg_q),
    .tick_out (tick_out)
);

// File: tb/tsd_timing_sel_test.sv
module tsd_timing_sel_test;

    localparam int NWS = 8;
    localparam int NCH = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCH-1:0]  wr_lane = '0;
    logic [31:0]     wr_data = '0;
    logic [5:1]      div_en = '0;
    logic [2:0]      ref_tick = '0;
    logic [1:0]      brg_tick = '0;
    logic [NWS-1:0]  ws_tick = '0;
    logic [NCH-1:0]  tick_out;

    tsd_timing_sel #(.NUM_WS(NWS), .NUM_CH(NCH)) uut (
        .clk(clk), .rst_n(rst_n), .wr_lane(wr_lane), .wr_data(wr_data),
        .div_en(div_en), .ref_tick(ref_tick), .brg_tick(brg_tick),
        .ws_tick(ws_tick), .tick_out(tick_out)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int m_sel [NCH];
    int m_idx [NCH];
    int m_mode[NCH];   // 0 hold, 1 count, 2 pass
    int m_cnt [NCH];
    int m_exp [NCH];

    bit count_en = 0;
    int pc    [NCH];

    function automatic int ref_factor(int idx);
        int f[30];
        if (idx > 29) return 0;
        for (int i = 0; i < 4; i++) f[i] = 2 * (i + 1);
        f[4] = 12;
        f[5] = 16;
        for (int i = 6; i < 29; i++) f[i] = 2 * f[i-2];
        f[29] = 2 * f[28];
        return f[idx];
    endfunction

    function automatic int ref_mode(int sel, int idx);
        if (sel <= 4) return (div_en[sel+1] && idx < 30) ? 1 : 0;
        if (sel == 5) return 0;
        return (sel - 6 < NWS) ? 2 : 0;
    endfunction

    function automatic bit ref_tick_of(int sel);
        if (sel <= 2) return ref_tick[sel];
        if (sel <= 4) return brg_tick[sel-3];
        if (sel >= 6 && sel - 6 < NWS) return ws_tick[sel-6];
        return 1'b0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_sel[c] = 0; m_idx[c] = 0; m_mode[c] = 0; m_cnt[c] = 0; m_exp[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                bit t;
                t = ref_tick_of(m_sel[c]);
                if (wr_lane[c]) begin
                    m_cnt[c] = 0; m_exp[c] = 0;
                end else if (m_mode[c] == 1) begin
                    m_exp[c] = 0;
                    if (t) begin
                        if (m_cnt[c] == ref_factor(m_idx[c]) - 1) begin
                            m_cnt[c] = 0; m_exp[c] = 1;
                        end else begin
                            m_cnt[c]++;
                        end
                    end
                end else if (m_mode[c] == 2) begin
                    m_cnt[c] = 0; m_exp[c] = t;
                end else begin
                    m_cnt[c] = 0; m_exp[c] = 0;
                end
                if (wr_lane[c]) begin
                    m_sel[c] = int'(wr_data[c*16+8 +: 4]);
                    m_idx[c] = int'(wr_data[c*16 +: 5]);
                end
                m_mode[c] = ref_mode(m_sel[c], m_idx[c]);
            end
        end
    end

    task automatic report();
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic chk(bit ok, string req, int act, int exp, string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the reference
    always @(negedge clk) begin
        if (!done) begin
            for (int c = 0; c < NCH; c++) begin
                chk(tick_out[c] === m_exp[c][0], cur_req, int'(tick_out[c]), m_exp[c],
                    $sformatf("ch%0d pulse", c));
                if (count_en && tick_out[c]) pc[c]++;
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 190000);
            report();
        end
    end

    task automatic run(int n, int dens);
        repeat (n) begin
            @(negedge clk);
            wr_lane = '0;
            for (int i = 0; i < 3; i++) ref_tick[i] = ($urandom % 100) < dens;
            for (int i = 0; i < 2; i++) brg_tick[i] = ($urandom % 100) < dens;
            for (int i = 0; i < NWS; i++) ws_tick[i] = ($urandom % 100) < dens;
        end
    endtask

    task automatic wr(logic [1:0] lanes, logic [31:0] d, int dens);
        @(negedge clk);
        wr_lane = lanes;
        wr_data = d;
        for (int i = 0; i < 3; i++) ref_tick[i] = ($urandom % 100) < dens;
        for (int i = 0; i < 2; i++) brg_tick[i] = ($urandom % 100) < dens;
        for (int i = 0; i < NWS; i++) ws_tick[i] = ($urandom % 100) < dens;
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        div_en = 5'b11111;
        repeat (3) @(negedge clk);
        chk(tick_out == '0, "R1", int'(tick_out), 0, "outputs in reset");
        rst_n = 1'b1;
        run(4, 0);
        chk(tick_out == '0, "R1", int'(tick_out), 0, "outputs after reset");

        // R2 R3 R4: masked bits ignored, reference sources, small factors
        cur_req = "R2 R3 R4";
        wr(2'b11, 32'hF1E3_F0E0, 60);
        run(300, 60);
        wr(2'b11, 32'h0304_0202, 70);
        run(400, 70);

        // R3 R5 R11: baud sources and table entries
        cur_req = "R3 R5 R11";
        wr(2'b11, 32'h030D_0405, 80);
        run(2000, 80);

        // R7: enable toggling
        cur_req = "R7";
        wr(2'b11, 32'h0406_0001, 70);
        for (int i = 0; i < 30; i++) begin
            div_en = 5'($urandom);
            run(40, 70);
        end
        div_en = 5'b11111;

        // R8: strobes, then absent sources
        cur_req = "R8";
        wr(2'b11, 32'h0D00_0600, 50);
        run(200, 50);
        wr(2'b11, 32'h0E00_0500, 50);
        run(200, 50);

        // R9: reserved indices
        cur_req = "R9";
        wr(2'b11, 32'h031F_001E, 90);
        run(200, 90);

        // R10 R12: lane rewrite clears one counter only
        cur_req = "R10 R12";
        wr(2'b11, 32'h0103_0003, 80);
        for (int i = 0; i < 20; i++) begin
            run(5, 80);
            wr(2'b01, 32'hAAAA_0003, 80);
        end
        run(50, 80);

        // R5 R6: longest factors at one tick per cycle
        cur_req = "R5 R6";
        wr(2'b11, 32'h011C_001D, 100);
        @(negedge clk);
        pc[0] = 0; pc[1] = 0;
        count_en = 1;
        run(98400, 100);
        count_en = 0;
        chk(pc[0] == 1, "R6", pc[0], 1, "index 29 pulse count");
        chk(pc[1] == 2, "R5", pc[1], 2, "index 28 pulse count");

        done = 1;
        report();
    end

endmodule